// File: doc/BRIEF.md
# ECP Parallel Port Transfer Controller

This block drives the host side of an IEEE 1284 parallel link that runs in ECP fashion. Host logic writes a 3-bit operating mode and a direction bit through a configuration strobe. In the two programmed modes (000 and 001) the strobe, host-acknowledge and data lines simply follow levels that software supplies. In the transfer mode (011) a state machine runs the handshake without software help. Going forward it sends bytes from a 16-entry byte queue to the peripheral. Going in reverse it collects bytes from the peripheral into that same queue.

Software fills the queue through two write ports: one for command (address/RLE) bytes and one for data bytes. Each queue entry keeps a tag bit that tells the two apart. On the link the tag sets the level of the host-acknowledge line. In reverse, software pops received bytes and their tags from the queue head. Mode changes are filtered so that only legal moves take effect. The direction can only change in mode 001. Leaving the transfer mode drops any handshake in progress at once. If the port was running in reverse, leaving also discards the bytes collected but not yet read.

The link state machine has eight states. ST_IDLE waits for work: it moves to ST_F_SETUP when going forward with the queue not empty, and to ST_R_WAIT when in reverse with the queue not full. The forward path runs ST_F_SETUP → ST_F_STROBE (strobe low) → ST_F_HOLD (when busy rises) → ST_F_POP (when busy falls) → ST_IDLE. The reverse path runs ST_R_WAIT → ST_R_ACKED (when ack falls) → ST_R_PUSH (when ack rises) → ST_IDLE. Every state goes straight to ST_IDLE whenever the mode is not 011.

Top module: `ecp_port_ctrl`

## Requirements
- R1: After reset the port is in mode 000 with direction 0, the queue is empty and not full, lnk_strobe_n and lnk_autofd_n are 1, and lnk_data_oe is 1.
- R2: A mode write is accepted when the current mode is 000 or 001, or when the requested mode is 000 or 001. Any other mode write leaves the mode unchanged.
- R3: A direction write takes effect only when the current mode is 001. In any other mode the direction is left unchanged.
- R4: A byte written on hw_addr_wr is queued with tag 1 (command), and a byte written on hw_data_wr is queued with tag 0 (data). If both strobes are high in the same cycle, one entry with tag 1 is queued. Both write strobes are ignored while the direction is 1.
- R5: The queue holds 16 entries in first-in first-out order and reports fifo_full and fifo_empty. A write made while the queue is full is dropped.
- R6: In mode 011 with direction 0, each queued entry is sent in this order: the byte is placed on lnk_data_out, and lnk_autofd_n is set to 1 for data or 0 for a command; then lnk_strobe_n falls.
- R7: During a forward transfer, lnk_strobe_n stays low until lnk_busy is 1, and then rises. The entry is popped only after lnk_busy returns to 0, and no new transfer starts before that. lnk_data_out stays stable while lnk_strobe_n is low.
- R8: In mode 011 with direction 1 and the queue not full, lnk_autofd_n is held at 0. When lnk_ack_n falls, the block latches lnk_data_in and a tag (1 when lnk_busy is 0, meaning command; 0 when lnk_busy is 1, meaning data), and raises lnk_autofd_n. When lnk_ack_n rises, it lowers lnk_autofd_n and queues the latched entry. lnk_strobe_n stays 1.
- R9: In reverse, while the queue is full, lnk_autofd_n is held at 1 and no byte is accepted. hr_pop removes the head entry only when the direction is 1 and the queue is not empty. hr_byte and hr_cmd show the head entry.
- R10: When the mode leaves 011, any transfer in progress is abandoned, and the state machine is idle one cycle later. If the direction was 1, the queue is emptied by that same mode write.
- R11: In any mode other than 011, lnk_strobe_n, lnk_autofd_n and lnk_data_out follow pio_strobe_n, pio_autofd_n and pio_data one cycle later.
- R12: lnk_data_oe is the inverse of the current direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Mode/direction write strobe |
| cfg_mode | input | 3 | Requested mode |
| cfg_dir | input | 1 | Requested direction (1 = reverse) |
| mode_q | output | 3 | Current mode |
| dir_q | output | 1 | Current direction |
| pio_strobe_n | input | 1 | Software strobe level for non-transfer modes |
| pio_autofd_n | input | 1 | Software host-acknowledge level for non-transfer modes |
| pio_data | input | 8 | Software data byte for non-transfer modes |
| hw_addr_wr | input | 1 | Queue a command (address/RLE) byte |
| hw_data_wr | input | 1 | Queue a data byte |
| hw_wr_byte | input | 8 | Byte for either write port |
| hr_pop | input | 1 | Pop the head entry (reverse only) |
| hr_byte | output | 8 | Head entry byte |
| hr_cmd | output | 1 | Head entry tag (1 = command) |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| lnk_data_out | output | 8 | Link data driven by the host |
| lnk_data_oe | output | 1 | Host data driver enable |
| lnk_data_in | input | 8 | Link data from the peripheral |
| lnk_strobe_n | output | 1 | Link strobe, active low |
| lnk_autofd_n | output | 1 | Link host-acknowledge line |
| lnk_busy | input | 1 | Peripheral busy / peripheral acknowledge |
| lnk_ack_n | input | 1 | Peripheral acknowledge, active low |

## Verification
The assertions assume that lnk_busy and lnk_ack_n are already synchronous to clk and change only between edges. They also assume that software leaves the transfer mode only after the forward queue has drained or while in reverse, so the forward strobe check never sees a programmed-mode level mixed into a transfer. The stimulus drives every input on the falling clock edge. It moves the peripheral lines only after the block has shown the handshake step that precedes them, so each wait in the bench is driven by the design's own outputs.

// File: rtl/ecp_pkg.sv
`timescale 1ns/1ps
package ecp_pkg;
    localparam int BYTE_W = 8;

    typedef logic [2:0] mode_t;
    localparam mode_t MODE_PIO_OUT = 3'b000;
    localparam mode_t MODE_PIO_BI  = 3'b001;
    localparam mode_t MODE_XFER    = 3'b011;

    typedef struct packed {
        logic              is_cmd;
        logic [BYTE_W-1:0] val;
    } entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_F_SETUP,
        ST_F_STROBE,
        ST_F_HOLD,
        ST_F_POP,
        ST_R_WAIT,
        ST_R_ACKED,
        ST_R_PUSH
    } lnk_state_t;
endpackage

// File: rtl/ecp_mode_reg.sv
`timescale 1ns/1ps
module ecp_mode_reg
    import ecp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_i,
    input  mode_t mode_i,
    input  logic  dir_i,
    output mode_t mode_o,
    output logic  dir_o,
    output logic  flush_o
);
    mode_t mode_q;
    logic  dir_q;
    logic  cur_pio, req_pio, mode_ok;

    assign cur_pio = (mode_q == MODE_PIO_OUT) || (mode_q == MODE_PIO_BI);
    assign req_pio = (mode_i == MODE_PIO_OUT) || (mode_i == MODE_PIO_BI);
    assign mode_ok = wr_i && (cur_pio || req_pio);
    assign flush_o = mode_ok && (mode_q == MODE_XFER) && (mode_i != MODE_XFER) && dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_PIO_OUT;
            dir_q  <= 1'b0;
        end else begin
            if (mode_ok)
                mode_q <= mode_i;
            if (wr_i && (mode_q == MODE_PIO_BI))
                dir_q <= dir_i;
        end
    end

    assign mode_o = mode_q;
    assign dir_o  = dir_q;

    // R2
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mode_q) && !$past(cur_pio)) |-> cur_pio);

    // R3
    dir_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_q) |-> ($past(mode_q) == MODE_PIO_BI));
endmodule

// File: rtl/ecp_byte_fifo.sv
`timescale 1ns/1ps
module ecp_byte_fifo
    import ecp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push_i,
    input  entry_t din_i,
    input  logic   pop_i,
    input  logic   flush_i,
    output entry_t dout_o,
    output logic   full_o,
    output logic   empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    entry_t        mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full_o  = (count == CW'(DEPTH));
    assign empty_o = (count == '0);
    assign do_push = push_i && !full_o && !flush_i;
    assign do_pop  = pop_i && !empty_o && !flush_i;
    assign dout_o  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);
endmodule

// File: rtl/ecp_link_fsm.sv
`timescale 1ns/1ps
module ecp_link_fsm
    import ecp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_i,
    input  logic              dir_i,
    input  logic              pio_strobe_n_i,
    input  logic              pio_autofd_n_i,
    input  logic [BYTE_W-1:0] pio_data_i,
    input  entry_t            head_i,
    input  logic              empty_i,
    input  logic              full_i,
    output logic              pop_o,
    output logic              push_o,
    output entry_t            rx_o,
    input  logic              busy_i,
    input  logic              ack_n_i,
    input  logic [BYTE_W-1:0] data_in_i,
    output logic              strobe_n_o,
    output logic              autofd_n_o,
    output logic [BYTE_W-1:0] data_o
);
    lnk_state_t        state, nxt;
    logic              strobe_q, autofd_q, n_strobe, n_autofd;
    logic [BYTE_W-1:0] data_q, n_data;
    entry_t            rx_q, n_rx;

    always_comb begin
        nxt      = state;
        n_strobe = strobe_q;
        n_autofd = autofd_q;
        n_data   = data_q;
        n_rx     = rx_q;
        if (!auto_i) begin
            nxt      = ST_IDLE;
            n_strobe = pio_strobe_n_i;
            n_autofd = pio_autofd_n_i;
            n_data   = pio_data_i;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    n_strobe = 1'b1;
                    if (!dir_i) begin
                        n_autofd = 1'b1;
                        if (!empty_i) begin
                            nxt      = ST_F_SETUP;
                            n_data   = head_i.val;
                            n_autofd = !head_i.is_cmd;
                        end
                    end else begin
                        n_autofd = full_i;
                        if (!full_i)
                            nxt = ST_R_WAIT;
                    end
                end
                ST_F_SETUP: begin
                    nxt      = ST_F_STROBE;
                    n_strobe = 1'b0;
                end
                ST_F_STROBE: begin
                    if (busy_i) begin
                        nxt      = ST_F_HOLD;
                        n_strobe = 1'b1;
                    end
                end
                ST_F_HOLD: begin
                    if (!busy_i)
                        nxt = ST_F_POP;
                end
                ST_F_POP: begin
                    nxt      = ST_IDLE;
                    n_autofd = 1'b1;
                end
                ST_R_WAIT: begin
                    if (!ack_n_i) begin
                        n_rx     = '{is_cmd: !busy_i, val: data_in_i};
                        n_autofd = 1'b1;
                        nxt      = ST_R_ACKED;
                    end
                end
                ST_R_ACKED: begin
                    if (ack_n_i) begin
                        n_autofd = 1'b0;
                        nxt      = ST_R_PUSH;
                    end
                end
                ST_R_PUSH: begin
                    nxt = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b1;
            autofd_q <= 1'b1;
            data_q   <= '0;
            rx_q     <= '0;
        end else begin
            strobe_q <= n_strobe;
            autofd_q <= n_autofd;
            data_q   <= n_data;
            rx_q     <= n_rx;
        end
    end

    assign pop_o      = auto_i && (state == ST_F_POP);
    assign push_o     = auto_i && (state == ST_R_PUSH);
    assign rx_o       = rx_q;
    assign strobe_n_o = strobe_q;
    assign autofd_n_o = autofd_q;
    assign data_o     = data_q;

    // R6
    strobe_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_i && $past(auto_i) && $fell(strobe_q)) |-> ($past(state) == ST_F_SETUP));

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_i && $past(auto_i) && !strobe_q && !$past(strobe_q)) |-> $stable(data_q));

    // R8
    rev_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_i && dir_i && $past(auto_i)) |-> strobe_q);

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(auto_i) |=> (state == ST_IDLE));
endmodule

// File: rtl/ecp_port_ctrl.sv
`timescale 1ns/1ps
module ecp_port_ctrl
    import ecp_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_dir,
    output logic [2:0]        mode_q,
    output logic              dir_q,
    input  logic              pio_strobe_n,
    input  logic              pio_autofd_n,
    input  logic [BYTE_W-1:0] pio_data,
    input  logic              hw_addr_wr,
    input  logic              hw_data_wr,
    input  logic [BYTE_W-1:0] hw_wr_byte,
    input  logic              hr_pop,
    output logic [BYTE_W-1:0] hr_byte,
    output logic              hr_cmd,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic [BYTE_W-1:0] lnk_data_out,
    output logic              lnk_data_oe,
    input  logic [BYTE_W-1:0] lnk_data_in,
    output logic              lnk_strobe_n,
    output logic              lnk_autofd_n,
    input  logic              lnk_busy,
    input  logic              lnk_ack_n
);
    mode_t  mode_w;
    logic   dir_w, flush_w, auto_w;
    logic   h_push, l_push, l_pop, h_pop, q_push, q_pop;
    entry_t h_entry, l_entry, q_din, q_head;
    logic   q_full, q_empty;

    ecp_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr),
        .mode_i  (cfg_mode),
        .dir_i   (cfg_dir),
        .mode_o  (mode_w),
        .dir_o   (dir_w),
        .flush_o (flush_w)
    );

    assign auto_w  = (mode_w == MODE_XFER);
    assign h_push  = !dir_w && (hw_addr_wr || hw_data_wr);
    assign h_entry = '{is_cmd: hw_addr_wr, val: hw_wr_byte};
    assign h_pop   = hr_pop && dir_w;
    assign q_push  = dir_w ? l_push : h_push;
    assign q_din   = dir_w ? l_entry : h_entry;
    assign q_pop   = dir_w ? h_pop : l_pop;

    ecp_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (q_push),
        .din_i   (q_din),
        .pop_i   (q_pop),
        .flush_i (flush_w),
        .dout_o  (q_head),
        .full_o  (q_full),
        .empty_o (q_empty)
    );

    ecp_link_fsm u_link (
        .clk            (clk),
        .rst_n          (rst_n),
        .auto_i         (auto_w),
        .dir_i          (dir_w),
        .pio_strobe_n_i (pio_strobe_n),
        .pio_autofd_n_i (pio_autofd_n),
        .pio_data_i     (pio_data),
        .head_i         (q_head),
        .empty_i        (q_empty),
        .full_i         (q_full),
        .pop_o          (l_pop),
        .push_o         (l_push),
        .rx_o           (l_entry),
        .busy_i         (lnk_busy),
        .ack_n_i        (lnk_ack_n),
        .data_in_i      (lnk_data_in),
        .strobe_n_o     (lnk_strobe_n),
        .autofd_n_o     (lnk_autofd_n),
        .data_o         (lnk_data_out)
    );

    assign mode_q      = mode_w;
    assign dir_q       = dir_w;
    assign hr_byte     = q_head.val;
    assign hr_cmd      = q_head.is_cmd;
    assign fifo_full   = q_full;
    assign fifo_empty  = q_empty;
    assign lnk_data_oe = !dir_w;

    // R4
    rev_no_host_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_w && $past(dir_w) && $past(q_empty) && !$past(auto_w) && !auto_w) |-> q_empty);
endmodule

// File: tb/ecp_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module ecp_port_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_mode = 3'b000;
    logic       cfg_dir = 1'b0;
    logic [2:0] mode_q;
    logic       dir_q;
    logic       pio_strobe_n = 1'b1;
    logic       pio_autofd_n = 1'b1;
    logic [7:0] pio_data = 8'h00;
    logic       hw_addr_wr = 1'b0;
    logic       hw_data_wr = 1'b0;
    logic [7:0] hw_wr_byte = 8'h00;
    logic       hr_pop = 1'b0;
    logic [7:0] hr_byte;
    logic       hr_cmd;
    logic       fifo_full, fifo_empty;
    logic [7:0] lnk_data_out;
    logic       lnk_data_oe;
    logic [7:0] lnk_data_in = 8'h00;
    logic       lnk_strobe_n, lnk_autofd_n;
    logic       lnk_busy = 1'b0;
    logic       lnk_ack_n = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ecp_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_dir(cfg_dir),
        .mode_q(mode_q), .dir_q(dir_q), .pio_strobe_n(pio_strobe_n), .pio_autofd_n(pio_autofd_n),
        .pio_data(pio_data), .hw_addr_wr(hw_addr_wr), .hw_data_wr(hw_data_wr),
        .hw_wr_byte(hw_wr_byte), .hr_pop(hr_pop), .hr_byte(hr_byte), .hr_cmd(hr_cmd),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .lnk_data_out(lnk_data_out),
        .lnk_data_oe(lnk_data_oe), .lnk_data_in(lnk_data_in), .lnk_strobe_n(lnk_strobe_n),
        .lnk_autofd_n(lnk_autofd_n), .lnk_busy(lnk_busy), .lnk_ack_n(lnk_ack_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg(input logic [2:0] m, input logic d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_mode = m; cfg_dir = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic host_wr(input logic a, input logic d, input logic [7:0] b);
        @(negedge clk);
        hw_addr_wr = a; hw_data_wr = d; hw_wr_byte = b;
        @(negedge clk);
        hw_addr_wr = 1'b0; hw_data_wr = 1'b0;
    endtask

    task automatic host_pop();
        @(negedge clk);
        hr_pop = 1'b1;
        @(negedge clk);
        hr_pop = 1'b0;
    endtask

    task automatic wait_strobe(input string req, input logic v);
        int n = 0;
        while (lnk_strobe_n !== v && n < 60) begin @(negedge clk); n++; end
        chk(req, lnk_strobe_n, v);
    endtask

    task automatic wait_autofd(input string req, input logic v);
        int n = 0;
        while (lnk_autofd_n !== v && n < 60) begin @(negedge clk); n++; end
        chk(req, lnk_autofd_n, v);
    endtask

    // One forward byte seen on the link
    task automatic fwd_byte(input logic [7:0] v, input logic is_cmd, input bit last);
        wait_strobe("R6 strobe falls", 1'b0);
        chk("R6 data on link", lnk_data_out, v);
        chk("R6 autofd tag level", lnk_autofd_n, !is_cmd);
        cyc(3);
        chk("R7 strobe held until busy", lnk_strobe_n, 0);
        lnk_busy = 1'b1;
        wait_strobe("R7 strobe rises after busy", 1'b1);
        cyc(3);
        chk("R7 no restart while busy", lnk_strobe_n, 1);
        if (last) chk("R7 no pop while busy", fifo_empty, 0);
        lnk_busy = 1'b0;
        cyc(2);
    endtask

    // One reverse byte offered by the peripheral
    task automatic rev_byte(input logic [7:0] v, input logic busy);
        lnk_data_in = v; lnk_busy = busy;
        @(negedge clk);
        lnk_ack_n = 1'b0;
        wait_autofd("R8 autofd rises on ack", 1'b1);
        lnk_data_in = ~v;
        @(negedge clk);
        lnk_ack_n = 1'b1;
        wait_autofd("R8 autofd drops after ack release", 1'b0);
        cyc(3);
    endtask

    task automatic t_reset();
        chk("R1 mode", mode_q, 0);
        chk("R1 dir", dir_q, 0);
        chk("R1 empty", fifo_empty, 1);
        chk("R1 full", fifo_full, 0);
        chk("R1 strobe", lnk_strobe_n, 1);
        chk("R1 autofd", lnk_autofd_n, 1);
        chk("R1 oe", lnk_data_oe, 1);
    endtask

    task automatic t_pio();
        @(negedge clk);
        pio_strobe_n = 1'b0; pio_autofd_n = 1'b0; pio_data = 8'hA5;
        cyc(2);
        chk("R11 strobe follows", lnk_strobe_n, 0);
        chk("R11 autofd follows", lnk_autofd_n, 0);
        chk("R11 data follows", lnk_data_out, 8'hA5);
        pio_strobe_n = 1'b1; pio_autofd_n = 1'b1;
        cyc(2);
        chk("R11 strobe released", lnk_strobe_n, 1);
    endtask

    task automatic t_mode();
        cfg(3'b011, 1'b1);
        chk("R2 000 to 011", mode_q, 3);
        chk("R3 dir ignored outside 001", dir_q, 0);
        cfg(3'b010, 1'b0);
        chk("R2 011 to 010 ignored", mode_q, 3);
        cfg(3'b001, 1'b0);
        chk("R2 011 to 001", mode_q, 1);
        cfg(3'b001, 1'b1);
        chk("R3 dir set in 001", dir_q, 1);
        chk("R12 oe off in reverse", lnk_data_oe, 0);
        cfg(3'b001, 1'b0);
        chk("R3 dir cleared in 001", dir_q, 0);
        cfg(3'b100, 1'b1);
        chk("R2 001 to 100", mode_q, 4);
        chk("R3 dir kept (old mode 001 took write)", dir_q, 1);
        cfg(3'b011, 1'b0);
        chk("R2 100 to 011 ignored", mode_q, 4);
        chk("R3 dir ignored in 100", dir_q, 1);
        cfg(3'b001, 1'b0);
        cfg(3'b001, 1'b0);
        chk("R3 dir back to 0", dir_q, 0);
        cfg(3'b000, 1'b0);
        chk("R2 back to 000", mode_q, 0);
    endtask

    task automatic t_fwd();
        host_wr(1'b1, 1'b0, 8'h12);
        host_wr(1'b0, 1'b1, 8'h34);
        host_wr(1'b1, 1'b1, 8'h56);
        chk("R4 queued", fifo_empty, 0);
        cyc(2);
        chk("R11 no auto strobe in 000", lnk_strobe_n, 1);
        cfg(3'b011, 1'b0);
        fwd_byte(8'h12, 1'b1, 1'b0);
        fwd_byte(8'h34, 1'b0, 1'b0);
        fwd_byte(8'h56, 1'b1, 1'b1);
        chk("R7 popped after busy low", fifo_empty, 1);
        chk("R6 idle autofd", lnk_autofd_n, 1);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 17; i++) host_wr(1'b0, 1'b1, 8'h80 + 8'(i));
        chk("R5 full", fifo_full, 1);
        for (int i = 0; i < 16; i++) fwd_byte(8'h80 + 8'(i), 1'b0, i == 15);
        chk("R5 drained", fifo_empty, 1);
        cyc(10);
        chk("R5 dropped write never sent", lnk_strobe_n, 1);
        cfg(3'b000, 1'b0);
        cfg(3'b001, 1'b0);
    endtask

    task automatic t_rev();
        cfg(3'b001, 1'b1);
        chk("R12 oe off", lnk_data_oe, 0);
        host_wr(1'b1, 1'b0, 8'hEE);
        host_wr(1'b0, 1'b1, 8'hEF);
        chk("R4 writes ignored in reverse", fifo_empty, 1);
        cfg(3'b011, 1'b1);
        cyc(2);
        chk("R8 ready level", lnk_autofd_n, 0);
        chk("R8 strobe idle", lnk_strobe_n, 1);
        rev_byte(8'h3C, 1'b1);
        rev_byte(8'hC3, 1'b0);
        chk("R8 byte queued", fifo_empty, 0);
        chk("R8 first byte", hr_byte, 8'h3C);
        chk("R8 data tag", hr_cmd, 0);
        host_pop();
        chk("R8 second byte", hr_byte, 8'hC3);
        chk("R8 command tag", hr_cmd, 1);
        host_pop();
        chk("R9 empty after pops", fifo_empty, 1);
        host_pop();
        chk("R9 pop on empty harmless", fifo_empty, 1);
        for (int i = 0; i < 16; i++) rev_byte(8'h40 + 8'(i), 1'b1);
        chk("R9 full", fifo_full, 1);
        chk("R9 not ready when full", lnk_autofd_n, 1);
        @(negedge clk); lnk_ack_n = 1'b0;
        cyc(5);
        chk("R9 no accept when full", lnk_autofd_n, 1);
        lnk_ack_n = 1'b1;
        cyc(2);
        chk("R9 head order", hr_byte, 8'h40);
        host_pop();
        cyc(2);
        chk("R9 ready after pop", lnk_autofd_n, 0);
        chk("R9 next head", hr_byte, 8'h41);
    endtask

    task automatic t_abort();
        @(negedge clk);
        lnk_data_in = 8'h99; lnk_busy = 1'b1; lnk_ack_n = 1'b0;
        wait_autofd("R10 mid-transfer", 1'b1);
        pio_autofd_n = 1'b0;
        cfg(3'b001, 1'b1);
        chk("R10 queue flushed", fifo_empty, 1);
        cyc(1);
        chk("R10 line follows software after exit", lnk_autofd_n, 0);
        lnk_ack_n = 1'b1;
        pio_autofd_n = 1'b1;
        cyc(2);
        chk("R10 no stray push", fifo_empty, 1);
        cfg(3'b011, 1'b1);
        cyc(2);
        chk("R10 restarted ready", lnk_autofd_n, 0);
        rev_byte(8'h77, 1'b1);
        chk("R10 fresh transfer", hr_byte, 8'h77);
        cfg(3'b001, 1'b1);
        cfg(3'b001, 1'b0);
        cfg(3'b000, 1'b0);
        chk("R12 oe back on", lnk_data_oe, 1);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_pio();
        t_mode();
        t_fwd();
        t_overflow();
        t_rev();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule